// File: doc/BRIEF.md
# UART Interrupt Combiner

This block merges the interrupt causes of one serial port channel into a single level-sensitive request line. Four cause bits (receive, error, transmit and modem) are collected in a source register. A mask register hides individual causes. The pending view is the source bits with the masked ones removed. The IRQ output is high while any pending bit is set. Software reaches all of this through a simple 32-bit register port with a write strobe and a combinational read path.

Beside the event inputs, the block raises the transmit cause in two ways. The first is a write to the transmit data location. The second is a comparison: while the FIFO-enable bit is on, the incoming transmit FIFO occupancy is compared with a trigger level. That level is a 3-bit field scaled by a multiplier, and the multiplier depends on the channel number fixed at elaboration. The FIFO storage and the shift engines live elsewhere.

Top module: `uirq_ctrl`

## Requirements
- R1: Source bit 0 is receive, bit 1 error, bit 2 transmit, bit 3 modem. A one on `ev_i[k]` at a clock edge sets source bit k, and the bit stays set until it is cleared. The source register is read at address 0.
- R2: The pending register (address 2) reads as source AND NOT mask. `irq` is high exactly when a pending bit is set.
- R3: A write to the mask register (address 1, bits [3:0]) takes effect on the pending value and on `irq` in the cycle after the write edge.
- R4: Writing ones to address 0 clears those source bits. Zero bits leave the source unchanged.
- R5: Writing ones to address 2 clears the same bits in the source, and so also in the pending register.
- R6: When a set (an event, a transmit data write or the threshold) and a software clear hit the same bit in the same cycle, the bit ends up set.
- R7: A write to address 5 (transmit data) sets source bit 2. It also sets bits 2 and 1 of the transmit status register at address 4, which reads zero after reset.
- R8: FIFO control is at address 3: bit 0 enables the FIFO and bits [10:8] hold the trigger field. The trigger level is the field times 32 for channel 0, times 8 for channels 1 and 4, and times 2 for channels 2 and 3. Any other channel gives a level of 0.
- R9: While bit 0 of FIFO control is set, source bit 2 is set at every edge where `tx_count` is less than or equal to the trigger level. While bit 0 is clear, the count has no effect.
- R10: After reset, source, mask, pending, FIFO control and status all read zero. FIFO control reads back only bits 0 and [10:8]. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| ev_i | input | 4 | Cause events: receive, error, transmit, modem |
| tx_count | input | CNT_W | Current transmit FIFO occupancy |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted source or mask bit shows up at the ports in the cycle after the faulty edge: `irq` takes the wrong level and the pending read disagrees with the source and mask reads. A wrong trigger level, or a bad comparison direction, only shows when the occupancy sits exactly on the level or one above it. For that reason the bench places `tx_count` on both sides of the boundary and uses several channel variants. A lost set-over-clear priority appears as a source bit that reads zero right after a same-cycle event and clear.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int NSRC      = 4;
   localparam int SRC_RX    = 0;
   localparam int SRC_ERR   = 1;
   localparam int SRC_TX    = 2;
   localparam int SRC_MODEM = 3;

   localparam int ADDR_W    = 3;
   localparam int FEN_BIT   = 0;
   localparam int TRIG_LSB  = 8;
   localparam int TRIG_W    = 3;
   localparam int TRIG_MSB  = TRIG_LSB + TRIG_W - 1;

   typedef enum logic [ADDR_W-1:0] {
      A_SRC    = 3'd0,
      A_MASK   = 3'd1,
      A_PEND   = 3'd2,
      A_FCTL   = 3'd3,
      A_TSTAT  = 3'd4,
      A_TXDATA = 3'd5
   } reg_addr_e;

   // Scale applied to the trigger field for a given channel
   function automatic int unsigned chan_mult(input int unsigned ch);
      case (ch)
         0:       return 32;
         1, 4:    return 8;
         2, 3:    return 2;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/uirq_txlevel.sv
module uirq_txlevel
   import uirq_pkg::*;
#(
   parameter int unsigned CHANNEL = 0,
   parameter int          CNT_W   = 8
) (
   input  logic [TRIG_W-1:0] field_i,
   output logic [CNT_W-1:0]  level_o
);
   localparam int unsigned MULT   = chan_mult(CHANNEL);
   localparam int unsigned MAXLVL = ((1 << TRIG_W) - 1) * MULT;

   generate
      if (CNT_W <= TRIG_W) begin : g_bad_width
         $error("uirq_txlevel: CNT_W must exceed the trigger field width");
      end
      if (MAXLVL >= (64'd1 << CNT_W)) begin : g_bad_range
         $error("uirq_txlevel: CNT_W too narrow for the largest trigger level");
      end

      if (MULT == 0) begin : g_none
         assign level_o = '0;
         logic unused_field;
         assign unused_field = ^field_i;
      end else begin : g_scaled
         assign level_o = {{(CNT_W-TRIG_W){1'b0}}, field_i} * CNT_W'(MULT);
      end
   endgenerate
endmodule

// File: rtl/uirq_srcreg.sv
module uirq_srcreg #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] src_o
);
   generate
      for (genvar k = 0; k < NSRC; k++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         src_o[k] <= 1'b0;
            else if (set_i[k])  src_o[k] <= 1'b1;
            else if (clr_i[k])  src_o[k] <= 1'b0;
         end
      end
   endgenerate

   // R1: every requested set is visible one edge later
   p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((src_o & $past(set_i)) == $past(set_i)));

   // R4: a clear without a competing set drops the bit
   p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((src_o & $past(clr_i & ~set_i)) == '0));

   // R6: no bit rises without a set request
   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((src_o & ~$past(src_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
   import uirq_pkg::*;
#(
   parameter int unsigned CHANNEL = 0,
   parameter int          CNT_W   = 8,
   parameter int          DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NSRC-1:0]   ev_i,
   input  logic [CNT_W-1:0]  tx_count,
   output logic              irq
);
   generate
      if (DATA_W <= TRIG_MSB) begin : g_bad_data
         $error("uirq_ctrl: DATA_W must cover the trigger field");
      end
   endgenerate

   logic              wr_src, wr_mask, wr_pend, wr_fctl, wr_txd;
   logic [NSRC-1:0]   src_q, mask_q, pend, set_v, clr_v;
   logic              fen_q;
   logic [TRIG_W-1:0] trig_q;
   logic [1:0]        tstat_q;
   logic [CNT_W-1:0]  trig_level;
   logic              at_thresh;

   assign wr_src  = reg_wr && (reg_addr == A_SRC);
   assign wr_mask = reg_wr && (reg_addr == A_MASK);
   assign wr_pend = reg_wr && (reg_addr == A_PEND);
   assign wr_fctl = reg_wr && (reg_addr == A_FCTL);
   assign wr_txd  = reg_wr && (reg_addr == A_TXDATA);

   uirq_txlevel #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_level (
      .field_i (trig_q),
      .level_o (trig_level)
   );

   assign at_thresh = fen_q && (tx_count <= trig_level);

   always_comb begin
      set_v = ev_i;
      set_v[SRC_TX] = ev_i[SRC_TX] | wr_txd | at_thresh;
      clr_v = (wr_src || wr_pend) ? reg_wdata[NSRC-1:0] : '0;
   end

   uirq_srcreg #(.NSRC(NSRC)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v),
      .clr_i (clr_v),
      .src_o (src_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         fen_q   <= 1'b0;
         trig_q  <= '0;
         tstat_q <= 2'b00;
      end else begin
         if (wr_mask) mask_q <= reg_wdata[NSRC-1:0];
         if (wr_fctl) begin
            fen_q  <= reg_wdata[FEN_BIT];
            trig_q <= reg_wdata[TRIG_MSB:TRIG_LSB];
         end
         if (wr_txd) tstat_q <= 2'b11;
      end
   end

   assign pend = src_q & ~mask_q;
   assign irq  = |pend;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_SRC:   reg_rdata[NSRC-1:0] = src_q;
         A_MASK:  reg_rdata[NSRC-1:0] = mask_q;
         A_PEND:  reg_rdata[NSRC-1:0] = pend;
         A_FCTL: begin
            reg_rdata[FEN_BIT]           = fen_q;
            reg_rdata[TRIG_MSB:TRIG_LSB] = trig_q;
         end
         A_TSTAT: reg_rdata[2:1] = tstat_q;
         default: reg_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[DATA_W-1:TRIG_MSB+1],
                           reg_wdata[TRIG_LSB-1:NSRC]};

   // R3: a mask write hides the written bits from pending on the next cycle
   p_mask_hides_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> ((pend & $past(reg_wdata[NSRC-1:0])) == '0));

   // R7: a transmit data write raises the transmit cause and both status bits
   p_txwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_txd |=> (src_q[SRC_TX] && (tstat_q == 2'b11)));

   // R9: occupancy at or under the level keeps the transmit cause set
   p_thresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
      at_thresh |=> src_q[SRC_TX]);

   // R2: a pending bit always comes from a set source bit
   p_irq_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|src_q));
endmodule

// File: tb/uirq_ctrl_bench.sv
module uirq_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int          inst;
      logic [31:0] rd;
      logic        irqv;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  ev_i = '0;
   logic [7:0]  tx_count = '0;
   logic [31:0] rd0, rd1, rd2;
   logic        irq0, irq1, irq2;

   int total = 0;
   int bad = 0;
   bit done = 0;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   uirq_ctrl #(.CHANNEL(0)) u_uirq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd0), .ev_i(ev_i),
      .tx_count(tx_count), .irq(irq0));
   uirq_ctrl #(.CHANNEL(3)) u_uirq_ctrl_ch3 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd1), .ev_i(ev_i),
      .tx_count(tx_count), .irq(irq1));
   uirq_ctrl #(.CHANNEL(5)) u_uirq_ctrl_ch5 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd2), .ev_i(ev_i),
      .tx_count(tx_count), .irq(irq2));

   // Monitor: compare each queued expectation half a cycle after it is posted
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [31:0] ard;
         logic        airq;
         it = q.pop_front();
         ard  = (it.inst == 0) ? rd0  : (it.inst == 1) ? rd1  : rd2;
         airq = (it.inst == 0) ? irq0 : (it.inst == 1) ? irq1 : irq2;
         total++;
         if (ard !== it.rd || airq !== it.irqv) begin
            bad++;
            $display("FAIL %s inst=%0d addr=%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                     it.req, it.inst, reg_addr, ard, airq, it.rd, it.irqv);
         end
      end
   end

   // Driver tasks: each starts and ends just after a rising edge
   task automatic wr(input logic [2:0] a, input logic [31:0] d,
                     input logic [3:0] ev = 4'd0);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; ev_i = ev;
      @(posedge clk); #1;
      reg_wr = 1'b0; ev_i = 4'd0;
   endtask

   task automatic pulse(input logic [3:0] ev);
      ev_i = ev;
      @(posedge clk); #1;
      ev_i = 4'd0;
   endtask

   task automatic idle();
      @(posedge clk); #1;
   endtask

   task automatic expect_rd(input int inst, input logic [2:0] a,
                            input logic [31:0] v, input logic iv, input string req);
      item_t it;
      reg_addr = a;
      it.inst = inst; it.rd = v; it.irqv = iv; it.req = req;
      q.push_back(it);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();

      // R10: reset state
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R10");
      expect_rd(0, 3'd1, 32'h0, 1'b0, "R10");
      expect_rd(0, 3'd2, 32'h0, 1'b0, "R10");
      expect_rd(0, 3'd3, 32'h0, 1'b0, "R10");
      expect_rd(0, 3'd4, 32'h0, 1'b0, "R10");
      expect_rd(0, 3'd7, 32'h0, 1'b0, "R10");

      // R1, R2: receive event
      pulse(4'b0001);
      expect_rd(0, 3'd0, 32'h1, 1'b1, "R1");
      expect_rd(0, 3'd2, 32'h1, 1'b1, "R2");

      // R3: mask and unmask
      wr(3'd1, 32'h1);
      expect_rd(0, 3'd2, 32'h0, 1'b0, "R3");
      expect_rd(0, 3'd0, 32'h1, 1'b0, "R2");
      wr(3'd1, 32'h0);
      expect_rd(0, 3'd2, 32'h1, 1'b1, "R3");

      // R4: clear through source register
      wr(3'd0, 32'h1);
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R4");

      // R1, R5: error and modem, clear error through pending
      pulse(4'b1010);
      expect_rd(0, 3'd0, 32'hA, 1'b1, "R1");
      wr(3'd2, 32'h2);
      expect_rd(0, 3'd0, 32'h8, 1'b1, "R5");
      expect_rd(0, 3'd2, 32'h8, 1'b1, "R5");

      // R6: set wins over a same-cycle clear
      wr(3'd0, 32'h8, 4'b1000);
      expect_rd(0, 3'd0, 32'h8, 1'b1, "R6");
      wr(3'd2, 32'h8, 4'b1000);
      expect_rd(0, 3'd0, 32'h8, 1'b1, "R6");
      wr(3'd0, 32'h8);
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R4");

      // R7: transmit data write
      wr(3'd5, 32'h41);
      expect_rd(0, 3'd0, 32'h4, 1'b1, "R7");
      expect_rd(0, 3'd4, 32'h6, 1'b1, "R7");
      wr(3'd1, 32'h4);
      expect_rd(0, 3'd2, 32'h0, 1'b0, "R2");
      wr(3'd1, 32'h0);
      wr(3'd0, 32'h4);
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R4");

      // R10, R9: readback width, level 224 boundary
      tx_count = 8'd255;
      wr(3'd3, 32'hFFFF_FFFF);
      expect_rd(0, 3'd3, 32'h701, 1'b0, "R10");
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R9");
      tx_count = 8'd224;
      idle();
      expect_rd(0, 3'd0, 32'h4, 1'b1, "R9");
      wr(3'd0, 32'h4);
      expect_rd(0, 3'd0, 32'h4, 1'b1, "R6");
      tx_count = 8'd225;
      wr(3'd0, 32'h4);
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R9");

      // R8: field 1 on channel 0 gives level 32
      wr(3'd3, 32'h101);
      tx_count = 8'd33;
      idle();
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R8");
      tx_count = 8'd32;
      idle();
      expect_rd(0, 3'd0, 32'h4, 1'b1, "R8");

      // R9: disabled FIFO ignores the count
      wr(3'd3, 32'h100);
      wr(3'd0, 32'h4);
      idle();
      expect_rd(0, 3'd0, 32'h0, 1'b0, "R9");

      // R8: field 0, count 0
      wr(3'd3, 32'h001);
      tx_count = 8'd0;
      idle();
      expect_rd(0, 3'd0, 32'h4, 1'b1, "R8");

      // R8: channel 3 (x2) and unsupported channel 5 (level 0)
      tx_count = 8'd7;
      wr(3'd3, 32'h301);
      wr(3'd0, 32'hF);
      idle();
      expect_rd(1, 3'd0, 32'h0, 1'b0, "R8");
      tx_count = 8'd6;
      idle();
      expect_rd(1, 3'd0, 32'h4, 1'b1, "R8");
      expect_rd(2, 3'd0, 32'h0, 1'b0, "R8");
      tx_count = 8'd0;
      idle();
      expect_rd(2, 3'd0, 32'h4, 1'b1, "R8");

      idle();
      idle();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule